// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 64-bit running tick count next to a 64-bit compare register and raises a one-cycle set pulse toward a software interrupt register when the count reaches the compare value. Bit 63 of each register is a control flag. In the count register it is a trap-on-read flag that is returned to software. In the compare register it is an interrupt-disable flag. The count advances by one on every clock in which the tick enable input is high, so an external divider sets the rate.

Software loads the count and the compare register through a single write port with a one-bit select. It reads the count, flag included, on a read port that is always valid. A parameter chooses the variant. The tick variant pulses softint bit 0 and the system-tick variant pulses softint bit 16. A compare value that is already at or behind the count fires on the next tick and does not wait for the counter to wrap. Each compare write arms at most one pulse, and reloading the count arms it again.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the trap flag is 1, the count is 0 (read value 0x8000_0000_0000_0000), the disable flag is 1 and no softint pulse is produced.
- R2: The 63-bit count goes up by one, wrapping modulo 2^63, on each clock with tick_en_i high and no count write. It holds while tick_en_i is low.
- R3: A count write (wr_sel_i = 0) loads bits 62:0 into the count and bit 63 into the trap flag. rd_data_o returns the trap flag in bit 63 and the count in bits 62:0.
- R4: A compare write (wr_sel_i = 1) takes bit 63 as the disable flag and bits 62:0 as the compare value. With the disable flag clear, the pulse comes out in the cycle after the tick edge that makes the count equal to the compare value.
- R5: A compare value of zero never produces a pulse.
- R6: While the disable flag is set no pulse is produced, even when the count passes the compare value.
- R7: If a compare value written is at or below the count at the time of the write, the pulse follows the next tick.
- R8: At most one pulse follows each compare write. Another pulse needs a new compare write or a count reload. A count reload cancels a pending past-value fire.
- R9: The pulse is on softint bit 0 for the tick variant and on bit 16 for the system-tick variant. All other softint bits stay 0.
- R10: A write in the same cycle as a tick takes priority. A count write then loads exactly the written value with no increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Advance the count on this clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 compare |
| wr_data_i | input | 64 | Write data, flag in bit 63 |
| rd_data_o | output | 64 | Count read value, trap flag in bit 63 |
| softint_set_o | output | 17 | One-cycle softint set pulse |

## Verification
A write is visible on rd_data_o one edge after it is driven, and each tick is visible one edge after the enabled cycle. The bench drives inputs on the falling edge and reads on the next falling edge. A pulse comes from a register loaded at the tick edge that reaches the compare value, so it shows at the falling edge straight after that edge. The bench counts pulses at every falling edge inside each tick window, which includes the last tick, so a pulse that is early, late or repeated changes the count. Both variants run the same stimulus side by side, and every sample compares the bit position of each variant's pulse.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned TICK_W    = 64;
  localparam int unsigned SI_W      = 17;
  localparam int unsigned TICK_BIT  = 0;
  localparam int unsigned STICK_BIT = 16;

  typedef enum logic {
    SEL_COUNT = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tick_cnt_reg.sv
module tick_cnt_reg #(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned VAL_W = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [VAL_W-1:0] cnt_o,
  output logic             npt_o
);
  logic [VAL_W-1:0] cnt_q;
  logic             npt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      npt_q <= 1'b1;
    end else if (load_i) begin
      cnt_q <= load_data_i[VAL_W-1:0];
      npt_q <= load_data_i[CNT_W-1];
    end else if (tick_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign npt_o = npt_q;

  a_r2_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r2_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !load_i) |=> $stable(cnt_q) && $stable(npt_q));

  a_r3_count_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_data_i[VAL_W-1:0])) && (npt_q == $past(load_data_i[CNT_W-1])));
endmodule

// File: rtl/tick_lim_reg.sv
module tick_lim_reg #(
  parameter int unsigned CNT_W = 64,
  localparam int unsigned VAL_W = CNT_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [VAL_W-1:0] lim_o,
  output logic             dis_o
);
  logic [VAL_W-1:0] lim_q;
  logic             dis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      dis_q <= 1'b1;
    end else if (load_i) begin
      lim_q <= load_data_i[VAL_W-1:0];
      dis_q <= load_data_i[CNT_W-1];
    end
  end

  assign lim_o = lim_q;
  assign dis_o = dis_q;

  a_r4_limit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lim_q == $past(load_data_i[VAL_W-1:0])) && (dis_q == $past(load_data_i[CNT_W-1])));

  a_r4_limit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lim_q) && $stable(dis_q));
endmodule

// File: rtl/tick_fire.sv
module tick_fire #(
  parameter int unsigned VAL_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             cnt_wr_i,
  input  logic             lim_wr_i,
  input  logic [VAL_W-1:0] new_lim_i,
  input  logic [VAL_W-1:0] cnt_i,
  input  logic [VAL_W-1:0] lim_i,
  input  logic             dis_i,
  output logic             fire_o
);
  logic             armed_q, past_q, fire_q;
  logic [VAL_W-1:0] cnt_nxt;
  logic             hit;

  assign cnt_nxt = cnt_i + 1'b1;

  // writes shadow the tick of the same cycle
  assign hit = tick_en_i && !cnt_wr_i && !lim_wr_i && armed_q && !dis_i &&
               (lim_i != '0) && (past_q || (cnt_nxt == lim_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      past_q  <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= hit;
      if (lim_wr_i) begin
        armed_q <= 1'b1;
        past_q  <= (new_lim_i <= cnt_i);
      end else if (cnt_wr_i) begin
        armed_q <= 1'b1;
        past_q  <= 1'b0;
      end else if (hit) begin
        armed_q <= 1'b0;
        past_q  <= 1'b0;
      end
    end
  end

  assign fire_o = fire_q;

  a_r5_zero_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i == '0) |=> !fire_o);

  a_r6_dis_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !fire_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> !$past(fire_o));

  a_r10_write_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i || lim_wr_i) |=> !fire_o);
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W    = TICK_W,
  parameter int unsigned SOFT_W   = SI_W,
  parameter bit          IS_STICK = 1'b0,
  localparam int unsigned VAL_W   = CNT_W - 1,
  localparam int unsigned OUT_BIT = IS_STICK ? STICK_BIT : TICK_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic [SOFT_W-1:0] softint_set_o
);
  reg_sel_e         sel;
  logic             cnt_wr, lim_wr;
  logic [VAL_W-1:0] cnt, lim;
  logic             npt, dis, fire;

  assign sel    = reg_sel_e'(wr_sel_i);
  assign cnt_wr = wr_en_i && (sel == SEL_COUNT);
  assign lim_wr = wr_en_i && (sel == SEL_LIMIT);

  tick_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .load_i     (cnt_wr),
    .load_data_i(wr_data_i),
    .cnt_o      (cnt),
    .npt_o      (npt)
  );

  tick_lim_reg #(.CNT_W(CNT_W)) u_lim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (lim_wr),
    .load_data_i(wr_data_i),
    .lim_o      (lim),
    .dis_o      (dis)
  );

  tick_fire #(.VAL_W(VAL_W)) u_fire (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_en_i(tick_en_i),
    .cnt_wr_i (cnt_wr),
    .lim_wr_i (lim_wr),
    .new_lim_i(wr_data_i[VAL_W-1:0]),
    .cnt_i    (cnt),
    .lim_i    (lim),
    .dis_i    (dis),
    .fire_o   (fire)
  );

  assign rd_data_o = {npt, cnt};

  for (genvar b = 0; b < SOFT_W; b++) begin : g_si
    if (b == OUT_BIT) begin : g_hit
      assign softint_set_o[b] = fire;
    end else begin : g_zero
      assign softint_set_o[b] = 1'b0;
    end
  end

  a_r9_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(softint_set_o));

  a_r3_read_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (rd_data_o == $past(wr_data_i)));
endmodule

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NV = 22;
  localparam logic [1:0] OP_WC = 2'd0, OP_WL = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] data;
    logic [7:0]  ticks;
    logic [63:0] exp_rd;
    logic [1:0]  exp_p;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{OP_WC, 64'h10, 8'd0, 64'h10, 2'd0, 4'd3},                                   // R3
    '{OP_TK, 64'h0, 8'd5, 64'h15, 2'd0, 4'd5},                                    // R5 reset limit
    '{OP_WL, 64'h18, 8'd0, 64'h15, 2'd0, 4'd4},                                   // R4
    '{OP_TK, 64'h0, 8'd5, 64'h1A, 2'd1, 4'd4},                                    // R4 match
    '{OP_TK, 64'h0, 8'd40, 64'h42, 2'd0, 4'd8},                                   // R8 once
    '{OP_WL, 64'h30, 8'd0, 64'h42, 2'd0, 4'd7},                                   // R7
    '{OP_TK, 64'h0, 8'd1, 64'h43, 2'd1, 4'd7},                                    // R7 next tick
    '{OP_TK, 64'h0, 8'd3, 64'h46, 2'd0, 4'd8},                                    // R8
    '{OP_WL, 64'h8000_0000_0000_0050, 8'd0, 64'h46, 2'd0, 4'd6},                  // R6
    '{OP_TK, 64'h0, 8'd20, 64'h5A, 2'd0, 4'd6},                                   // R6 crossing
    '{OP_WL, 64'h0, 8'd0, 64'h5A, 2'd0, 4'd5},                                    // R5
    '{OP_TK, 64'h0, 8'd5, 64'h5F, 2'd0, 4'd5},                                    // R5
    '{OP_WL, 64'h64, 8'd0, 64'h5F, 2'd0, 4'd4},                                   // R4
    '{OP_WC, 64'h8000_0000_0000_0060, 8'd0, 64'h8000_0000_0000_0060, 2'd0, 4'd3}, // R3 flag
    '{OP_TK, 64'h0, 8'd8, 64'h8000_0000_0000_0068, 2'd1, 4'd3},                   // R3 read
    '{OP_WC, 64'h60, 8'd0, 64'h60, 2'd0, 4'd8},                                   // R8 reload
    '{OP_TK, 64'h0, 8'd8, 64'h68, 2'd1, 4'd8},                                    // R8 rearmed
    '{OP_WL, 64'h68, 8'd0, 64'h68, 2'd0, 4'd7},                                   // R7 equal
    '{OP_TK, 64'h0, 8'd1, 64'h69, 2'd1, 4'd7},                                    // R7
    '{OP_WL, 64'h1, 8'd0, 64'h69, 2'd0, 4'd7},                                    // R7 past, pending
    '{OP_WC, 64'h7FFF_FFFF_FFFF_FFFE, 8'd0, 64'h7FFF_FFFF_FFFF_FFFE, 2'd0, 4'd8}, // R8 reload
    '{OP_TK, 64'h0, 8'd3, 64'h1, 2'd1, 4'd2}                                      // R2 wrap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0, rd1;
  logic [16:0] si0, si1;
  int          n_tests = 0, n_fail = 0, var_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_cmp_timer #(.IS_STICK(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_data_o(rd0), .softint_set_o(si0));

  tick_cmp_timer #(.IS_STICK(1'b1)) u_dut_sys (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_data_o(rd1), .softint_set_o(si1));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [63:0] d, input logic tk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick_en = tk;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic do_tick(input int n, output int pulses);
    pulses = 0;
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (si0[0]) pulses++;
      if (si0 != {16'h0, si0[0]}) var_bad++;
      if (si1 != {si0[0], 16'h0}) var_bad++;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 read", rd0, 64'h8000_0000_0000_0000);
    check("R1 softint", {47'h0, si0}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 write beats tick
    do_write(1'b0, 64'h200, 1'b1);
    check("R10 load no inc", rd0, 64'h200);
    // R2 hold with tick_en low
    repeat (5) @(negedge clk);
    check("R2 hold", rd0, 64'h200);
    // R5/R6 reset limit disabled: no pulse
    do_tick(4, p);
    check("R2 step", rd0, 64'h204);
    check("R6 reset disabled", p, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].op == OP_TK) begin
        do_tick(int'(VEC[k].ticks), p);
        n_tests++;
        if (p != int'(VEC[k].exp_p)) begin
          n_fail++;
          $display("FAIL R%0d row %0d pulses actual=%0d expected=%0d", VEC[k].req, k, p, VEC[k].exp_p);
        end
      end else begin
        do_write(VEC[k].op == OP_WL, VEC[k].data, 1'b0);
      end
      n_tests++;
      if (rd0 !== VEC[k].exp_rd) begin
        n_fail++;
        $display("FAIL R%0d row %0d read actual=%h expected=%h", VEC[k].req, k, rd0, VEC[k].exp_rd);
      end
    end

    // R9 both variants, pulse bit positions
    check("R9 variant bits", var_bad, 0);
    check("R9 variant read", rd1, rd0);

    // R1 mid-run reset: flags back, counter from zero, no fire
    do_write(1'b1, 64'h3, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset read", rd0, 64'h8000_0000_0000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    do_tick(5, p);
    check("R1 reset count", rd0, 64'h8000_0000_0000_0005);
    check("R1 disabled after reset", p, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule